// File: doc/BRIEF.md
# Local Interrupt Source Router

This block sits inside the processor-side interrupt controller. It gathers the requests of six local sources and turns each one into a single vector-plus-type request to the core. The six sources are two external interrupt pins, a timer-expiry strobe, a counter-overflow strobe, a thermal-trip strobe and an internal error strobe. Every source owns a programmable entry that sets its vector, its delivery type, its trigger mode (for the pins only) and its mask. Each entry also shows a read-only pending flag.

Software programs the entries through a small register port with one-cycle registered reads. An access to any address with no entry behind it counts as an error event. That event feeds the error source, which is then delivered through its own entry like any other source. When several sources are pending, requests leave one at a time. Urgent (non-maskable) requests go before ordinary ones, and inside each class a fixed source ranking applies. The core sees each request held steady until it acknowledges it.

Top module: `lvt_router`

## Requirements
- R1: After reset every entry reads as 0x0001_0000 (mask bit 16 set, all other bits 0), no source is pending, and `irq_valid_o` is low.
- R2: Entry word layout: bits 7:0 vector, bits 10:8 delivery type (000 fixed, 100 NMI, 111 external controller), bit 12 pending (read-only), bit 15 trigger mode (1 = level), bit 16 mask (1 = masked); other bits read 0. Addresses 0 to 5 map to pin 0, pin 1, timer, counter overflow, thermal, error. A write changes only the addressed entry. Bit 15 is stored only in the two pin entries and reads 0 in the others.
- R3: A pin in edge mode delivers exactly one request for each rising edge after synchronisation, however long the pin stays high.
- R4: A pin in level mode delivers again after an acknowledge only if it is still high after that acknowledge. Once it has dropped, no further request follows.
- R5: A masked source never delivers. An edge that arrives while masked is dropped for good. A level that is still high when the mask is cleared is delivered.
- R6: An entry with delivery type 100 (NMI) sends vector `NMI_VECTOR` (default 2), whatever its vector field holds, with type 100.
- R7: Among pending unmasked sources, NMI-typed ones go first. Within a class the order is error, thermal, counter overflow, timer, pin 1, pin 0.
- R8: While `irq_valid_o` is high and `irq_ack_i` is low, vector and type stay unchanged. An acknowledge drops `irq_valid_o` on the next cycle and clears the chosen source's pending bit.
- R9: A read or write to an address of 6 or above reads back 0, changes no entry, and raises the error source.
- R10: A one-cycle strobe on the timer, counter-overflow, thermal or error input delivers one request with that source's vector and type.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 2 | Asynchronous external interrupt pins (bit 0 = pin 0) |
| tmr_hit_i | input | 1 | Timer reached its programmed count (one-cycle strobe) |
| pmc_ovf_i | input | 1 | Performance counter overflow strobe |
| thermal_trip_i | input | 1 | Thermal sensor trip strobe |
| err_flag_i | input | 1 | Internal error strobe from the rest of the controller |
| cfg_wr_i | input | 1 | Entry write enable |
| cfg_rd_i | input | 1 | Entry read enable |
| cfg_addr_i | input | ADDR_W | Entry address |
| cfg_wdata_i | input | DATA_W | Write data |
| cfg_rdata_o | output | DATA_W | Read data, valid the cycle after `cfg_rd_i` |
| irq_valid_o | output | 1 | Request to the core is valid |
| irq_vector_o | output | 8 | Vector of the request |
| irq_type_o | output | 3 | Delivery type of the request |
| irq_ack_i | input | 1 | Core acknowledge of the current request |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 instead of the default 2. This runs the deeper branch of the synchroniser generate loop and moves pin delivery one cycle later, which the reference model must match exactly. `DATA_W` stays at 32, so the unused upper write bits and the zero read-back of the upper bits are exercised. `ADDR_W` stays at 4, which leaves ten unimplemented addresses (6 to 15) for the error path.

// File: rtl/lvt_pkg.sv
package lvt_pkg;

   localparam int NUM_SRC = 6;
   localparam int NUM_PIN = 2;
   localparam int SRC_W   = 3;
   localparam int VEC_W   = 8;
   localparam int TYP_W   = 3;

   // source slots; the order is also the ranking (higher index wins)
   localparam int SRC_PIN0  = 0;
   localparam int SRC_PIN1  = 1;
   localparam int SRC_TMR   = 2;
   localparam int SRC_PMC   = 3;
   localparam int SRC_THERM = 4;
   localparam int SRC_ERR   = 5;

   // entry word field positions
   localparam int F_VEC_LO  = 0;
   localparam int F_TYP_LO  = 8;
   localparam int F_PEND    = 12;
   localparam int F_TRIG    = 15;
   localparam int F_MASK    = 16;
   localparam int WORD_USED = 17;

   localparam logic [TYP_W-1:0] DLV_FIXED = 3'b000;
   localparam logic [TYP_W-1:0] DLV_NMI   = 3'b100;
   localparam logic [TYP_W-1:0] DLV_EXT   = 3'b111;

   typedef struct packed {
      logic             mask;
      logic             trig_lvl;
      logic [TYP_W-1:0] dtype;
      logic [VEC_W-1:0] vec;
   } cfg_t;

   // returns {found, index of highest set bit}
   function automatic logic [SRC_W:0] pick_top(input logic [NUM_SRC-1:0] c);
      logic [SRC_W:0] r;
      r = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (c[i]) r = {1'b1, SRC_W'(i)};
      end
      return r;
   endfunction

endpackage

// File: rtl/lvt_pin_sync.sv
module lvt_pin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("lvt_pin_sync: STAGES must be at least 2");
      end
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               chain_q[s] <= 1'b0;
            end else begin
               if (s == 0) chain_q[s] <= pin_i;
               else        chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= chain_q[STAGES-1];
   end

   assign level_o = chain_q[STAGES-1];
   assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/lvt_entry.sv
module lvt_entry
   import lvt_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter bit HAS_TRIG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [VEC_W-1:0]  wr_vec_i,
   input  logic [TYP_W-1:0]  wr_typ_i,
   input  logic              wr_trig_i,
   input  logic              wr_mask_i,
   input  logic              evt_i,
   input  logic              lvl_i,
   input  logic              clr_i,
   output cfg_t              cfg_o,
   output logic              pend_o,
   output logic [DATA_W-1:0] word_o
);

   logic [VEC_W-1:0] vec_q;
   logic [TYP_W-1:0] typ_q;
   logic             mask_q;
   logic             trig_q;
   logic             pend_q;
   logic             set_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q  <= '0;
         typ_q  <= DLV_FIXED;
         mask_q <= 1'b1;
      end else if (wr_i) begin
         vec_q  <= wr_vec_i;
         typ_q  <= wr_typ_i;
         mask_q <= wr_mask_i;
      end
   end

   generate
      if (HAS_TRIG) begin : g_trig
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    trig_q <= 1'b0;
            else if (wr_i) trig_q <= wr_trig_i;
         end
         // level sources re-arm only after the clearing acknowledge
         always_comb begin
            if (trig_q) set_req = lvl_i & ~mask_q & ~clr_i;
            else        set_req = evt_i & ~mask_q;
         end
      end else begin : g_edge_only
         wire unused_trig = wr_trig_i ^ lvl_i;
         assign trig_q  = 1'b0;
         assign set_req = evt_i & ~mask_q;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= (pend_q & ~clr_i) | set_req;
   end

   assign cfg_o  = '{mask: mask_q, trig_lvl: trig_q, dtype: typ_q, vec: vec_q};
   assign pend_o = pend_q;

   always_comb begin
      word_o = '0;
      word_o[F_VEC_LO +: VEC_W] = vec_q;
      word_o[F_TYP_LO +: TYP_W] = typ_q;
      word_o[F_PEND]            = pend_q;
      word_o[F_TRIG]            = trig_q;
      word_o[F_MASK]            = mask_q;
   end

endmodule

// File: rtl/lvt_dispatch.sv
module lvt_dispatch
   import lvt_pkg::*;
#(
   parameter int NMI_VECTOR = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_SRC-1:0]  pend_i,
   input  cfg_t [NUM_SRC-1:0]  cfg_i,
   input  logic                ack_i,
   output logic                valid_o,
   output logic [VEC_W-1:0]    vector_o,
   output logic [TYP_W-1:0]    dtype_o,
   output logic [SRC_W-1:0]    src_o,
   output logic [NUM_SRC-1:0]  clr_o
);

   logic [NUM_SRC-1:0] cand;
   logic [NUM_SRC-1:0] urg;
   logic [SRC_W:0]     pk_urg;
   logic [SRC_W:0]     pk_all;
   logic               pk_any;
   logic [SRC_W-1:0]   pk_idx;
   cfg_t               sel;

   logic               valid_q;
   logic [VEC_W-1:0]   vector_q;
   logic [TYP_W-1:0]   dtype_q;
   logic [SRC_W-1:0]   src_q;

   always_comb begin
      for (int i = 0; i < NUM_SRC; i++) begin
         cand[i] = pend_i[i] & ~cfg_i[i].mask;
         urg[i]  = cand[i] & (cfg_i[i].dtype == DLV_NMI);
      end
      pk_urg = pick_top(urg);
      pk_all = pick_top(cand);
      pk_any = pk_all[SRC_W];
      pk_idx = pk_urg[SRC_W] ? pk_urg[SRC_W-1:0] : pk_all[SRC_W-1:0];
      sel    = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (pk_idx == SRC_W'(i)) sel = cfg_i[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q  <= 1'b0;
         vector_q <= '0;
         dtype_q  <= DLV_FIXED;
         src_q    <= '0;
      end else if (valid_q) begin
         if (ack_i) valid_q <= 1'b0;
      end else if (pk_any) begin
         valid_q  <= 1'b1;
         src_q    <= pk_idx;
         dtype_q  <= sel.dtype;
         vector_q <= (sel.dtype == DLV_NMI) ? VEC_W'(NMI_VECTOR) : sel.vec;
      end
   end

   assign clr_o    = (valid_q && ack_i) ? (NUM_SRC'(1) << src_q) : '0;
   assign valid_o  = valid_q;
   assign vector_o = vector_q;
   assign dtype_o  = dtype_q;
   assign src_o    = src_q;

endmodule

// File: rtl/lvt_router.sv
module lvt_router
   import lvt_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int NMI_VECTOR  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        ext_pin_i,
   input  logic              tmr_hit_i,
   input  logic              pmc_ovf_i,
   input  logic              thermal_trip_i,
   input  logic              err_flag_i,
   input  logic              cfg_wr_i,
   input  logic              cfg_rd_i,
   input  logic [ADDR_W-1:0] cfg_addr_i,
   input  logic [DATA_W-1:0] cfg_wdata_i,
   output logic [DATA_W-1:0] cfg_rdata_o,
   output logic              irq_valid_o,
   output logic [7:0]        irq_vector_o,
   output logic [2:0]        irq_type_o,
   input  logic              irq_ack_i
);

   localparam int ADDR_SPAN = 1 << ADDR_W;

   generate
      if (DATA_W < WORD_USED) begin : g_chk_data
         $error("lvt_router: DATA_W too small for the entry word");
      end
      if (ADDR_SPAN <= NUM_SRC) begin : g_chk_addr
         $error("lvt_router: ADDR_W leaves no room for the entries");
      end
      if (SYNC_STAGES < 2) begin : g_chk_sync
         $error("lvt_router: SYNC_STAGES must be at least 2");
      end
      if (NMI_VECTOR < 0 || NMI_VECTOR >= (1 << VEC_W)) begin : g_chk_nmi
         $error("lvt_router: NMI_VECTOR does not fit the vector field");
      end
      if (DATA_W > WORD_USED) begin : g_spare
         wire unused_wdata_hi = ^cfg_wdata_i[DATA_W-1:WORD_USED];
      end
   endgenerate

   cfg_t [NUM_SRC-1:0]  cfg_q;
   logic [NUM_SRC-1:0]  pend_vec;
   logic [NUM_SRC-1:0]  mask_vec;
   logic [NUM_SRC-1:0]  evt_vec;
   logic [NUM_SRC-1:0]  lvl_vec;
   logic [NUM_SRC-1:0]  clr_vec;
   logic [NUM_SRC-1:0]  wr_sel;
   logic [DATA_W-1:0]   word_arr [NUM_SRC];
   logic [DATA_W-1:0]   rd_mux;
   logic [DATA_W-1:0]   rdata_q;
   logic                addr_ok;
   logic                bad_acc;
   logic                err_q;
   logic [SRC_W-1:0]    dsp_src;
   logic                unused_trig_hi;

   assign addr_ok = (cfg_addr_i < ADDR_W'(NUM_SRC));
   assign bad_acc = (cfg_wr_i | cfg_rd_i) & ~addr_ok;
   assign unused_trig_hi = cfg_wdata_i[F_PEND] ^ cfg_wdata_i[11] ^ ^cfg_wdata_i[14:13];

   // pin synchronisers and edge detectors
   generate
      for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
         lvt_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .pin_i   (ext_pin_i[p]),
            .level_o (lvl_vec[p]),
            .rise_o  (evt_vec[p])
         );
      end
   endgenerate

   assign lvl_vec[NUM_SRC-1:NUM_PIN] = '0;
   assign evt_vec[SRC_TMR]   = tmr_hit_i;
   assign evt_vec[SRC_PMC]   = pmc_ovf_i;
   assign evt_vec[SRC_THERM] = thermal_trip_i;
   assign evt_vec[SRC_ERR]   = err_flag_i | err_q;

   // unimplemented-address detector feeds the error source one cycle later
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= bad_acc;
   end

   // one entry per source; only the pin entries keep a trigger bit
   generate
      for (genvar i = 0; i < NUM_SRC; i++) begin : g_ent
         assign wr_sel[i] = cfg_wr_i & (cfg_addr_i == ADDR_W'(i));
         lvt_entry #(
            .DATA_W   (DATA_W),
            .HAS_TRIG (i < NUM_PIN)
         ) u_ent (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_i      (wr_sel[i]),
            .wr_vec_i  (cfg_wdata_i[F_VEC_LO +: VEC_W]),
            .wr_typ_i  (cfg_wdata_i[F_TYP_LO +: TYP_W]),
            .wr_trig_i (cfg_wdata_i[F_TRIG]),
            .wr_mask_i (cfg_wdata_i[F_MASK]),
            .evt_i     (evt_vec[i]),
            .lvl_i     (lvl_vec[i]),
            .clr_i     (clr_vec[i]),
            .cfg_o     (cfg_q[i]),
            .pend_o    (pend_vec[i]),
            .word_o    (word_arr[i])
         );
         assign mask_vec[i] = cfg_q[i].mask;
      end
   endgenerate

   // registered read port
   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (cfg_addr_i == ADDR_W'(i)) rd_mux = word_arr[i];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (cfg_rd_i) rdata_q <= addr_ok ? rd_mux : '0;
   end

   assign cfg_rdata_o = rdata_q;

   lvt_dispatch #(.NMI_VECTOR(NMI_VECTOR)) u_dsp (
      .clk      (clk),
      .rst_n    (rst_n),
      .pend_i   (pend_vec),
      .cfg_i    (cfg_q),
      .ack_i    (irq_ack_i),
      .valid_o  (irq_valid_o),
      .vector_o (irq_vector_o),
      .dtype_o  (irq_type_o),
      .src_o    (dsp_src),
      .clr_o    (clr_vec)
   );

endmodule

// File: rtl/lvt_router_chk.sv
module lvt_router_chk
   import lvt_pkg::*;
#(
   parameter int ADDR_W     = 4,
   parameter int NMI_VECTOR = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               reg_wr,
   input logic               reg_rd,
   input logic [ADDR_W-1:0]  reg_addr,
   input logic               irq_valid,
   input logic [7:0]         irq_vector,
   input logic [2:0]         irq_type,
   input logic               irq_ack,
   input logic [SRC_W-1:0]   src_q,
   input logic [NUM_SRC-1:0] mask_vec,
   input logic [NUM_SRC-1:0] pend_vec
);

   assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && !irq_ack |=> irq_valid && $stable(irq_vector) && $stable(irq_type));

   assert_ack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && irq_ack |=> !irq_valid);

   assert_nmi_vector_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_valid && (irq_type == DLV_NMI) |-> irq_vector == 8'(NMI_VECTOR));

   assert_no_masked_launch_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_valid) |-> ($past(mask_vec) & (NUM_SRC'(1) << src_q)) == '0);

   assert_bad_addr_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr || reg_rd) && (reg_addr >= ADDR_W'(NUM_SRC))
      |=> ##1 (pend_vec[SRC_ERR] || $past(mask_vec[SRC_ERR])));

endmodule

bind lvt_router lvt_router_chk #(.ADDR_W(ADDR_W), .NMI_VECTOR(NMI_VECTOR)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (cfg_wr_i),
   .reg_rd     (cfg_rd_i),
   .reg_addr   (cfg_addr_i),
   .irq_valid  (irq_valid_o),
   .irq_vector (irq_vector_o),
   .irq_type   (irq_type_o),
   .irq_ack    (irq_ack_i),
   .src_q      (dsp_src),
   .mask_vec   (mask_vec),
   .pend_vec   (pend_vec)
);

// File: tb/lvt_router_tb.sv
module lvt_router_tb_top;

   localparam int SYNC = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  ext_pin = 2'b00;
   logic        tmr = 1'b0, pmc = 1'b0, thm = 1'b0, erri = 1'b0;
   logic        wr = 1'b0, rd = 1'b0;
   logic [3:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_valid;
   logic [7:0]  irq_vector;
   logic [2:0]  irq_type;
   logic        ack = 1'b0;

   int total = 0;
   int bad = 0;
   int cycles = 0;
   bit done = 0;

   always #4 clk = ~clk;

   lvt_router #(.DATA_W(32), .ADDR_W(4), .SYNC_STAGES(SYNC), .NMI_VECTOR(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .ext_pin_i(ext_pin),
      .tmr_hit_i(tmr), .pmc_ovf_i(pmc), .thermal_trip_i(thm), .err_flag_i(erri),
      .cfg_wr_i(wr), .cfg_rd_i(rd), .cfg_addr_i(addr), .cfg_wdata_i(wdata),
      .cfg_rdata_o(rdata), .irq_valid_o(irq_valid), .irq_vector_o(irq_vector),
      .irq_type_o(irq_type), .irq_ack_i(ack)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [SYNC-1:0] m_sh [2];
   bit m_prev [2];
   int m_vec [6];
   int m_typ [6];
   bit m_lvl [6];
   bit m_msk [6];
   bit m_pend [6];
   bit m_ov;
   int m_src, m_ovec, m_otyp;
   logic [31:0] m_rdata;
   bit m_errq;

   function automatic logic [31:0] m_word(input int i);
      return 32'(m_vec[i]) | (32'(m_typ[i]) << 8) | (32'(m_pend[i]) << 12)
           | (32'(m_lvl[i]) << 15) | (32'(m_msk[i]) << 16);
   endfunction

   task automatic m_reset();
      for (int i = 0; i < 6; i++) begin
         m_vec[i] = 0; m_typ[i] = 0; m_lvl[i] = 0; m_msk[i] = 1; m_pend[i] = 0;
      end
      for (int p = 0; p < 2; p++) begin m_sh[p] = '0; m_prev[p] = 0; end
      m_ov = 0; m_src = 0; m_ovec = 0; m_otyp = 0; m_rdata = '0; m_errq = 0;
   endtask

   task automatic m_step();
      bit ev [6];
      bit np [6];
      bit clr, set, lv;
      int best;
      for (int p = 0; p < 2; p++) ev[p] = m_sh[p][SYNC-1] && !m_prev[p];
      ev[2] = tmr; ev[3] = pmc; ev[4] = thm; ev[5] = erri || m_errq;
      for (int i = 0; i < 6; i++) begin
         clr = m_ov && ack && (m_src == i);
         lv  = (i < 2) ? m_sh[i][SYNC-1] : 1'b0;
         if (m_lvl[i]) set = lv && !m_msk[i] && !clr;
         else          set = ev[i] && !m_msk[i];
         np[i] = (m_pend[i] && !clr) || set;
      end
      if (rd) m_rdata = (addr < 6) ? m_word(int'(addr)) : 32'h0;
      if (m_ov) begin
         if (ack) m_ov = 0;
      end else begin
         best = -1;
         for (int i = 0; i < 6; i++) if (m_pend[i] && !m_msk[i] && m_typ[i] == 4) best = i;
         if (best < 0)
            for (int i = 0; i < 6; i++) if (m_pend[i] && !m_msk[i]) best = i;
         if (best >= 0) begin
            m_ov = 1; m_src = best; m_otyp = m_typ[best];
            m_ovec = (m_typ[best] == 4) ? 2 : m_vec[best];
         end
      end
      if (wr && addr < 6) begin
         m_vec[addr] = int'(wdata[7:0]);
         m_typ[addr] = int'(wdata[10:8]);
         m_msk[addr] = wdata[16];
         m_lvl[addr] = (addr < 2) ? wdata[15] : 1'b0;
      end
      for (int i = 0; i < 6; i++) m_pend[i] = np[i];
      for (int p = 0; p < 2; p++) begin
         m_prev[p] = m_sh[p][SYNC-1];
         m_sh[p] = {m_sh[p][SYNC-2:0], ext_pin[p]};
      end
      m_errq = (wr || rd) && (addr >= 6);
   endtask

   initial m_reset();

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) m_reset();
      else        m_step();
   end

   // per-cycle comparison against the model (R8 output behaviour, R2 read data)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R8 model valid", 32'(irq_valid), 32'(m_ov));
         if (m_ov) begin
            chk("R7 model vector", 32'(irq_vector), 32'(m_ovec));
            chk("R2 model type", 32'(irq_type), 32'(m_otyp));
         end
         chk("R2 model rdata", rdata, m_rdata);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk); wr = 1; addr = a; wdata = d;
      @(negedge clk); wr = 0;
   endtask

   task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk); rd = 1; addr = a;
      @(negedge clk); rd = 0; d = rdata;
   endtask

   task automatic wait_irq(input int lim, output bit got);
      got = 0;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (irq_valid) begin got = 1; break; end
      end
   endtask

   task automatic do_ack();
      ack = 1;
      @(negedge clk); ack = 0;
   endtask

   task automatic count_valid(input int lim, output int n);
      n = 0;
      for (int k = 0; k < lim; k++) begin
         @(negedge clk);
         if (irq_valid) n++;
      end
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      case (which)
         2: tmr = 1; 3: pmc = 1; 4: thm = 1; default: erri = 1;
      endcase
      @(negedge clk); tmr = 0; pmc = 0; thm = 0; erri = 0;
   endtask

   // ---------------- watchdog ----------------
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog expired (R8 progress) act=%0d exp<150000", cycles);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   // ---------------- directed sequence ----------------
   initial begin
      logic [31:0] d;
      logic [7:0] v;
      bit got;
      int n;
      int exp_seq [4];

      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1 reset state
      chk("R1 no request after reset", 32'(irq_valid), 32'd0);
      reg_read(4'd0, d); chk("R1 pin0 entry reset", d, 32'h0001_0000);
      reg_read(4'd5, d); chk("R1 error entry reset", d, 32'h0001_0000);

      // R2 layout and independence
      reg_write(4'd3, 32'h0000_8123);
      reg_read(4'd3, d); chk("R2 trigger bit dropped in counter entry", d, 32'h0000_0123);
      reg_read(4'd4, d); chk("R2 thermal entry untouched", d, 32'h0001_0000);
      reg_write(4'd0, 32'h0001_8030);
      reg_read(4'd0, d); chk("R2 pin entry keeps trigger bit", d, 32'h0001_8030);

      // R10 timer strobe, R8 hold and pending clear
      reg_write(4'd2, 32'h0000_0041);
      pulse(2);
      wait_irq(10, got);
      chk("R10 timer delivers", 32'(got), 32'd1);
      chk("R10 timer vector", 32'(irq_vector), 32'h41);
      chk("R10 timer type fixed", 32'(irq_type), 32'd0);
      v = irq_vector;
      reg_read(4'd2, d); chk("R8 pending shown while in flight", d, 32'h0000_1041);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk("R8 request held", 32'(irq_vector), 32'(v));
      end
      do_ack();
      chk("R8 valid drops after ack", 32'(irq_valid), 32'd0);
      reg_read(4'd2, d); chk("R8 pending cleared by ack", d, 32'h0000_0041);

      // R3 pin edge: one request per edge
      reg_write(4'd0, 32'h0000_0030);
      ext_pin[0] = 1;
      wait_irq(12, got);
      chk("R3 pin0 edge delivers", 32'(got), 32'd1);
      chk("R3 pin0 vector", 32'(irq_vector), 32'h30);
      do_ack();
      count_valid(12, n);
      chk("R3 held pin delivers once", 32'(n), 32'd0);
      ext_pin[0] = 0;
      repeat (SYNC + 2) @(negedge clk);

      // R5 masked edge is dropped
      reg_write(4'd1, 32'h0001_0031);
      ext_pin[1] = 1;
      repeat (6) @(negedge clk);
      ext_pin[1] = 0;
      repeat (6) @(negedge clk);
      reg_write(4'd1, 32'h0000_0031);
      count_valid(10, n);
      chk("R5 masked edge discarded", 32'(n), 32'd0);

      // R5 masked level delivered on unmask, R4 re-delivery rules
      reg_write(4'd1, 32'h0001_8031);
      ext_pin[1] = 1;
      count_valid(8, n);
      chk("R5 masked level held off", 32'(n), 32'd0);
      reg_write(4'd1, 32'h0000_8031);
      wait_irq(6, got);
      chk("R5 level delivered after unmask", 32'(got), 32'd1);
      chk("R5 level vector", 32'(irq_vector), 32'h31);
      do_ack();
      wait_irq(6, got);
      chk("R4 level still high re-delivers", 32'(got), 32'd1);
      ext_pin[1] = 0;
      repeat (SYNC + 2) @(negedge clk);
      do_ack();
      count_valid(10, n);
      chk("R4 dropped level stops", 32'(n), 32'd0);
      reg_write(4'd1, 32'h0001_0031);

      // R6 NMI from pin 0
      reg_write(4'd0, 32'h0000_0455);
      ext_pin[0] = 1;
      wait_irq(12, got);
      chk("R6 nmi delivered", 32'(got), 32'd1);
      chk("R6 nmi vector", 32'(irq_vector), 32'd2);
      chk("R6 nmi type", 32'(irq_type), 32'd4);
      do_ack();
      ext_pin[0] = 0;
      reg_write(4'd0, 32'h0001_0000);
      repeat (SYNC + 2) @(negedge clk);

      // R7 fixed ranking with simultaneous strobes
      reg_write(4'd5, 32'h0000_0060);
      reg_write(4'd4, 32'h0000_0050);
      reg_write(4'd3, 32'h0000_0040);
      reg_write(4'd2, 32'h0000_0041);
      @(negedge clk); tmr = 1; pmc = 1; thm = 1; erri = 1;
      @(negedge clk); tmr = 0; pmc = 0; thm = 0; erri = 0;
      exp_seq = '{32'h60, 32'h50, 32'h40, 32'h41};
      for (int k = 0; k < 4; k++) begin
         wait_irq(10, got);
         chk("R7 ranking order", 32'(irq_vector), 32'(exp_seq[k]));
         do_ack();
      end

      // R7 NMI class first
      reg_write(4'd2, 32'h0000_0441);
      @(negedge clk); tmr = 1; pmc = 1; thm = 1; erri = 1;
      @(negedge clk); tmr = 0; pmc = 0; thm = 0; erri = 0;
      exp_seq = '{32'h02, 32'h60, 32'h50, 32'h40};
      for (int k = 0; k < 4; k++) begin
         wait_irq(10, got);
         chk("R7 nmi before fixed", 32'(irq_vector), 32'(exp_seq[k]));
         do_ack();
      end

      // R9 unimplemented address
      reg_read(4'd9, d); chk("R9 bad address reads zero", d, 32'h0);
      wait_irq(10, got);
      chk("R9 bad read raises error source", 32'(irq_vector), 32'h60);
      do_ack();
      reg_write(4'd7, 32'h0000_00FF);
      wait_irq(10, got);
      chk("R9 bad write raises error source", 32'(got), 32'd1);
      do_ack();
      reg_read(4'd5, d); chk("R9 error entry unchanged", d, 32'h0000_0060);

      repeat (4) @(negedge clk);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule